// File: doc/BRIEF.md
# Pipeline Activity Idle Detector

This block tells a multi-stage pipeline whether it has any outstanding work, so that a clock controller can safely stop it. It tracks two kinds of work. The first is traffic still in flight between stages. A one-bit flag enters a shift line whenever a stage writes an inter-stage buffer, and it moves one slot on each pipeline advance. The line is as long as the slowest inter-stage buffer, so a flag leaves it when the data it stands for has arrived. The second kind is stages that hold themselves awake through explicit activate and deactivate requests.

No OR tree runs across the flags every cycle. A single saturating counter is updated incrementally: it goes up when a flag enters or a stage wakes, and down when a flag expires or a stage sleeps. The pipeline is reported busy whenever the counter is nonzero. Software or a controller can preload the counter. A large preload keeps the pipeline permanently awake, and a zero preload forces an idle indication.

Top module: `act_idle_top`

## Requirements
- R1: While `rst_ni` is low, every flag slot and every stage bit is cleared and `cnt_o` is 0. After release, with no requests, `cnt_o` stays 0 and `active_o` stays 0.
- R2: `wr_i` in a cycle without `adv_i` marks slot 0 and adds 1 to the counter only if slot 0 was empty; a second `wr_i` while slot 0 is still marked leaves the counter unchanged.
- R3: On `adv_i` every flag moves one slot toward the oldest slot (index `LAT-1`); a marked flag leaving the oldest slot subtracts 1, so a flag written once is removed on the `LAT`-th advance after its write.
- R4: Bit k of `act_i` on an inactive stage k adds 1 and marks it active; bit k of `deact_i` on an active stage subtracts 1 and marks it inactive; a redundant request, or both requests on the same stage in one cycle, changes nothing.
- R5: `active_o` is 1 exactly when `cnt_o` is nonzero.
- R6: `load_i` writes `load_val_i` into the counter on the next edge, overriding every increment and decrement of that cycle; flag slots and stage bits still update as usual.
- R7: When `adv_i` and `wr_i` share a cycle, the expiry of the oldest slot is applied first and the write lands in the vacated slot 0, so an expiry and a new write give a net change of zero.
- R8: The counter saturates: it never wraps below 0 nor above 2^`CNT_W`-1.
- R9: Requests on several stages in one cycle are all counted, together with any flag change in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Some stage wrote an inter-stage buffer this cycle |
| adv_i | input | 1 | Pipeline advance strobe |
| act_i | input | NS | Per-stage activate requests |
| deact_i | input | NS | Per-stage deactivate requests |
| load_i | input | 1 | Preload the counter |
| load_val_i | input | CNT_W | Preload value |
| cnt_o | output | CNT_W | Activity counter |
| active_o | output | 1 | Pipeline has outstanding work |

## Verification
The functions that collide are the expiry of the oldest flag on an advance and the marking of slot 0 by a new write. The bench places a single flag, advances it until it sits in the oldest slot, and then drives `adv_i` and `wr_i` together. It expects the counter to hold its value, and it expects the new flag to expire only after another full `LAT` advances. A reference model in the bench applies the expiry before the mark, and a randomized phase mixes both with stage requests and checks every cycle against that model.

// File: rtl/act_idle_pkg.sv
package act_idle_pkg;

  function automatic int popcnt(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/act_flag_line.sv
module act_flag_line #(
  parameter int LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic adv_i,
  output logic mark_o,
  output logic expire_o
);

  logic [LAT-1:0] slot_q, slot_d, shifted;

  generate
    if (LAT == 1) begin : g_one
      assign shifted = '0;
    end else begin : g_many
      assign shifted = {slot_q[LAT-2:0], 1'b0};
    end
  endgenerate

  always_comb begin
    logic [LAT-1:0] base;
    base     = adv_i ? shifted : slot_q;
    expire_o = adv_i & slot_q[LAT-1];
    mark_o   = wr_i & ~base[0];           // write lands after expiry/shift
    slot_d   = base;
    if (wr_i) slot_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  assert_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> slot_q[0]);

  generate
    if (LAT > 1) begin : g_chk
      assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> slot_q[LAT-1] == $past(slot_q[LAT-2]));
    end
  endgenerate

endmodule

// File: rtl/act_stage_track.sv
module act_stage_track
  import act_idle_pkg::*;
#(
  parameter int NS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] act_i,
  input  logic [NS-1:0] deact_i,
  output int            n_up_o,
  output int            n_dn_o
);

  logic [NS-1:0] stage_q, rise, fall;

  assign rise   = act_i & ~deact_i & ~stage_q;
  assign fall   = deact_i & ~act_i & stage_q;
  assign n_up_o = popcnt(32'(rise), NS);
  assign n_dn_o = popcnt(32'(fall), NS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= (stage_q | rise) & ~fall;
  end

  assert_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stage_q & $past(act_i & ~deact_i)) == $past(act_i & ~deact_i)));
  assert_sleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stage_q & $past(deact_i & ~act_i)) == '0));

endmodule

// File: rtl/act_counter.sv
module act_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mark_i,
  input  logic             expire_i,
  input  int               n_up_i,
  input  int               n_dn_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  int sum;

  always_comb begin
    sum = int'(cnt_q) + int'(mark_i) + n_up_i - int'(expire_i) - n_dn_i;
    if (load_i)             cnt_d = load_val_i;
    else if (sum < 0)       cnt_d = '0;
    else if (sum > CNT_MAX) cnt_d = CNT_W'(CNT_MAX);
    else                    cnt_d = CNT_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mark_i && n_up_i == 0) |=> cnt_q <= $past(cnt_q));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mark_i && expire_i && n_up_i == 0 && n_dn_i == 0) |=> $stable(cnt_q));

endmodule

// File: rtl/act_idle_top.sv
module act_idle_top #(
  parameter int NS    = 4,
  parameter int LAT   = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             adv_i,
  input  logic [NS-1:0]    act_i,
  input  logic [NS-1:0]    deact_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);

  localparam int MIN_W = $clog2(LAT + NS + 1);

  logic mark, expire;
  int   n_up, n_dn;

  initial begin
    if (CNT_W < MIN_W) $error("CNT_W too narrow for LAT+NS");
  end

  act_flag_line #(.LAT(LAT)) u_line (
    .clk_i, .rst_ni, .wr_i, .adv_i, .mark_o(mark), .expire_o(expire)
  );

  act_stage_track #(.NS(NS)) u_stage (
    .clk_i, .rst_ni, .act_i, .deact_i, .n_up_o(n_up), .n_dn_o(n_dn)
  );

  act_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mark_i(mark), .expire_i(expire), .n_up_i(n_up),
    .n_dn_i(n_dn), .load_i, .load_val_i, .cnt_o
  );

  assign active_o = |cnt_o;

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> !active_o);
  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !adv_i && !load_i && act_i == '0 && deact_i == '0) |=> $stable(cnt_o));

endmodule

// File: tb/tb_act_idle_top.sv
module tb_act_idle_top;
  localparam int NS = 4, LAT = 4, CNT_W = 6;
  localparam int CMAX = (1 << CNT_W) - 1;

  typedef struct { int cnt; string tag; } exp_t;

  logic clk_i = 0, rst_ni = 0, wr_i = 0, adv_i = 0, load_i = 0;
  logic [NS-1:0] act_i = '0, deact_i = '0;
  logic [CNT_W-1:0] load_val_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic active_o;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  bit m_slot[LAT];
  bit m_stage[NS];
  int m_cnt = 0;

  always #4 clk_i = ~clk_i;

  act_idle_top #(.NS(NS), .LAT(LAT), .CNT_W(CNT_W)) dut (.*);

  task automatic check(int exp, string tag);
    checks++;
    if (int'(cnt_o) != exp || active_o != (exp != 0)) begin
      fails++;
      $display("FAIL %s: cnt=%0d active=%0b expected cnt=%0d active=%0b",
               tag, cnt_o, active_o, exp, exp != 0);
    end
  endtask

  task automatic step(bit wr, bit adv, logic [NS-1:0] act, logic [NS-1:0] deact,
                      bit ld, int ldv, string tag);
    bit expire, mark;
    int sum;
    exp_t e;
    @(negedge clk_i);
    wr_i = wr; adv_i = adv; act_i = act; deact_i = deact;
    load_i = ld; load_val_i = CNT_W'(ldv);
    expire = adv && m_slot[LAT-1];
    if (adv) begin
      for (int i = LAT-1; i > 0; i--) m_slot[i] = m_slot[i-1];
      m_slot[0] = 0;
    end
    mark = wr && !m_slot[0];
    if (wr) m_slot[0] = 1;
    sum = m_cnt + int'(mark) - int'(expire);
    for (int k = 0; k < NS; k++) begin
      if (act[k] && !deact[k] && !m_stage[k]) begin m_stage[k] = 1; sum++; end
      else if (deact[k] && !act[k] && m_stage[k]) begin m_stage[k] = 0; sum--; end
    end
    if (ld) m_cnt = ldv;
    else m_cnt = (sum < 0) ? 0 : (sum > CMAX) ? CMAX : sum;
    e.cnt = m_cnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.cnt, e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk_i);
    #1 check(0, "R1 in reset");
    @(negedge clk_i) rst_ni = 1;
    #1 check(0, "R1 after release");
    idle(2, "R1 quiet");
    // R2 mark and duplicate write
    step(1, 0, '0, '0, 0, 0, "R2 first write");
    step(1, 0, '0, '0, 0, 0, "R2 repeat write");
    // R3 flag leaves on the LAT-th advance
    for (int i = 0; i < LAT; i++) step(0, 1, '0, '0, 0, 0, "R3 advance");
    // R7 expiry and write collide
    step(1, 0, '0, '0, 0, 0, "R7 seed");
    for (int i = 0; i < LAT-1; i++) step(0, 1, '0, '0, 0, 0, "R7 move");
    step(1, 1, '0, '0, 0, 0, "R7 collide");
    for (int i = 0; i < LAT; i++) step(0, 1, '0, '0, 0, 0, "R7 drain");
    // R4 / R9 stage requests
    step(0, 0, 4'b0011, '0, 0, 0, "R9 two wake");
    step(0, 0, 4'b0001, '0, 0, 0, "R4 redundant wake");
    step(0, 0, '0, 4'b0001, 0, 0, "R4 sleep");
    step(0, 0, '0, 4'b0001, 0, 0, "R4 redundant sleep");
    step(0, 0, 4'b0100, 4'b0100, 0, 0, "R4 both ignored");
    step(1, 0, 4'b1100, 4'b0010, 0, 0, "R9 mixed");
    step(0, 0, '0, 4'b1100, 0, 0, "R9 two sleep");
    for (int i = 0; i < LAT; i++) step(0, 1, '0, '0, 0, 0, "R3 drain");
    // R6 load overrides
    step(0, 0, 4'b0001, '0, 1, 10, "R6 load over wake");
    step(0, 0, '0, 4'b0001, 0, 0, "R6 stage still tracked");
    step(0, 0, '0, '0, 1, 0, "R6 load zero");
    // R8 saturation
    step(0, 0, '0, '0, 1, CMAX, "R8 load max");
    step(0, 0, 4'b0010, '0, 0, 0, "R8 top clamp");
    step(1, 0, '0, '0, 1, 0, "R8 load zero with flag");
    step(0, 0, '0, 4'b0010, 0, 0, "R8 bottom clamp");
    for (int i = 0; i < LAT; i++) step(0, 1, '0, '0, 0, 0, "R8 expire at zero");
    idle(1, "R5 idle");
    // mixed random traffic
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), NS'($urandom), NS'($urandom),
           ($urandom_range(0, 19) == 0), $urandom_range(0, 12), "R7 random");
    idle(2, "R5 tail");
    @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule